// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus placed in front of a 256-byte, byte-addressed memory. It oversamples the clock and data lines with a fast system clock, finds START and STOP conditions, and answers to a seven-bit device address. That address is a fixed four-bit type code followed by three strap pins. Masters can write a single byte or a page of bytes, and can read from the current address, from a random address, or sequentially.

Written bytes are held in a one-page buffer. They reach the memory only when the master ends the write with STOP. The commit is followed by a timed busy window in which the slave refuses its own address, so a master can poll for completion. A separate protection block grants or denies each write address. Denied bytes are still acknowledged but are never stored. A single address register serves both reads and writes. It wraps from FFh to 00h.

Top module: `twi_mem_slave`

## Requirements
- R1: The first byte after START is taken MSB first as {type code 1010, strap[2], strap[1], strap[0], R/W}, where R/W = 1 is a read. When it matches, the slave acknowledges by driving SDA low (sda_low_o = 1) through the ninth SCL pulse.
- R2: A control byte whose type code or strap bits differ gets no acknowledge. The slave then leaves SDA alone until the next START.
- R3: A write is a control byte, then a memory address byte, then data bytes, and the slave acknowledges each of them. The data reaches memory only after STOP. Within a page of 8 bytes, successive bytes advance the low 3 address bits, which wrap while the upper 5 bits stay fixed.
- R4: A write that ends with a repeated START rather than STOP commits nothing and starts no busy window.
- R5: After a commit, control bytes get no acknowledge until the busy window of BUSY_CYCLES system clocks has expired. After that, a poll is acknowledged.
- R6: A data byte whose target address is denied by perm_ok_i is acknowledged but not written.
- R7: The address register resets to 00h. After each byte written or read it points one past that byte. A current-address read returns the byte at that address.
- R8: A random read is a write of the control byte and the address byte, then a repeated START, then a read control byte. It returns the byte at the given address.
- R9: A read continues for as long as the master acknowledges each byte, and the address wraps from FFh to 00h. After a master NACK the slave releases SDA.
- R10: A START or STOP in the middle of a byte abandons that byte. A partial data byte is never written, and a new START is decoded as a fresh control byte.
- R11: sda_low_o changes only while the synchronized SCL is low, except where it is released by START or STOP. It is 0 after reset.
- R12: mem_we_o is asserted only during a commit that follows STOP. The consecutive writes of one commit stay in one 8-byte page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wire) |
| sda_low_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| strap_i | input | 3 | Device-select strap pins |
| perm_addr_o | output | 8 | Address of the data byte being received, for the protection block |
| perm_ok_i | input | 1 | 1 when a write to perm_addr_o is permitted |
| mem_addr_o | output | 8 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after mem_addr_o |

## Verification
The assertions check the following on every cycle:
- the slave never pulls SDA low while the busy window runs;
- a commit begins only right after a STOP;
- a busy window always follows a commit;
- memory writes within one commit stay inside a single page;
- the data drive changes only while SCL is low.

Some behaviour cannot be seen by the checker and is shown only by the bench's directed transactions. This covers which bytes end up in memory, the page wrap, dropped protected bytes, discarded writes after a repeated START or a mid-byte STOP, and the read address running past FFh. The same holds for the number of polls refused before the busy window ends.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int TWI_BYTE_W = 8;
    localparam int TWI_CNT_W  = 4;
    localparam logic [TWI_CNT_W-1:0] TWI_ACK_SLOT = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] prev_d, prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;
        always_comb chain_d = {chain_q[STAGES-2:0], raw[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end
        assign lvl[g] = chain_q[STAGES-1];
    end

    always_comb prev_d = lvl;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= prev_d;
    end

    assign scl_o      = lvl[0];
    assign sda_o      = lvl[1];
    assign scl_rise_o = lvl[0] & ~prev_q[0];
    assign scl_fall_o = ~lvl[0] & prev_q[0];
    assign start_o    = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
    assign stop_o     = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 2000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr_i,
    input  logic [twi_pkg::TWI_BYTE_W-$clog2(PAGE_BYTES)-1:0] page_i,
    input  logic                                  cap_en_i,
    input  logic [$clog2(PAGE_BYTES)-1:0]         cap_idx_i,
    input  logic [twi_pkg::TWI_BYTE_W-1:0]        cap_data_i,
    input  logic                                  cap_keep_i,
    input  logic                                  commit_i,
    output logic                                  active_o,
    output logic                                  busy_o,
    output logic                                  mem_we_o,
    output logic [twi_pkg::TWI_BYTE_W-1:0]        mem_addr_o,
    output logic [twi_pkg::TWI_BYTE_W-1:0]        mem_wdata_o
);
    import twi_pkg::*;

    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = TWI_BYTE_W - IDX_W;
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 2);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][TWI_BYTE_W-1:0] data;
        logic [PAGE_BYTES-1:0]                 keep;
        logic [PAGE_W-1:0]                     page;
        logic                                  run;
        logic [IDX_W-1:0]                      idx;
        logic [CNT_W-1:0]                      cnt;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.keep = '0;
            d.page = page_i;
        end
        if (cap_en_i) begin
            d.data[cap_idx_i] = cap_data_i;
            d.keep[cap_idx_i] = cap_keep_i;
        end
        if (q.run) begin
            if (q.idx == LAST_IDX) begin
                d.run  = 1'b0;
                d.keep = '0;
                d.cnt  = CNT_W'(BUSY_CYCLES);
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else if (commit_i) begin
            d.run = 1'b1;
            d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active_o    = q.run;
    assign busy_o      = q.run | (q.cnt != '0);
    assign mem_we_o    = q.run & q.keep[q.idx];
    assign mem_addr_o  = {q.page, q.idx};
    assign mem_wdata_o = q.data[q.idx];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter int          PAGE_BYTES  = 8,
    parameter int          BUSY_CYCLES = 2000,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  TYPE_CODE   = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_low_o,
    input  logic [2:0] strap_i,
    output logic [7:0] perm_addr_o,
    input  logic       perm_ok_i,
    output logic [7:0] mem_addr_o,
    output logic       mem_we_o,
    output logic [7:0] mem_wdata_o,
    input  logic [7:0] mem_rdata_i
);
    import twi_pkg::*;

    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = TWI_BYTE_W - IDX_W;

    typedef struct packed {
        twi_state_e            st;
        logic                  ack;
        logic [TWI_CNT_W-1:0]  cnt;
        logic [TWI_BYTE_W-1:0] sr;
        logic [TWI_BYTE_W-1:0] tx;
        logic                  rw;
        logic                  drv;
        logic                  mack;
        logic [TWI_BYTE_W-1:0] addr;
        logic [IDX_W-1:0]      wptr;
        logic                  pend;
    } ctl_t;

    ctl_t q, d;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic buf_clr, buf_cap, buf_commit, buf_active, buf_busy, buf_we;
    logic [TWI_BYTE_W-1:0] buf_addr, buf_wdata;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_lvl),
        .sda_o     (sda_lvl),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (ev_start),
        .stop_o    (ev_stop)
    );

    twi_page_buf #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (buf_clr),
        .page_i     (q.sr[TWI_BYTE_W-1:IDX_W]),
        .cap_en_i   (buf_cap),
        .cap_idx_i  (q.wptr),
        .cap_data_i (q.sr),
        .cap_keep_i (perm_ok_i),
        .commit_i   (buf_commit),
        .active_o   (buf_active),
        .busy_o     (buf_busy),
        .mem_we_o   (buf_we),
        .mem_addr_o (buf_addr),
        .mem_wdata_o(buf_wdata)
    );

    always_comb begin
        d          = q;
        buf_clr    = 1'b0;
        buf_cap    = 1'b0;
        buf_commit = 1'b0;
        if (ev_start) begin
            d.st   = ST_CTRL;
            d.cnt  = '0;
            d.ack  = 1'b0;
            d.drv  = 1'b0;
            d.pend = 1'b0;
        end else if (ev_stop) begin
            buf_commit = q.pend;
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.ack  = 1'b0;
            d.drv  = 1'b0;
            d.pend = 1'b0;
        end else begin
            case (q.st)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && !q.ack && q.cnt < TWI_ACK_SLOT) begin
                        d.sr  = {q.sr[TWI_BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && !q.ack && q.cnt == TWI_ACK_SLOT) begin
                        case (q.st)
                            ST_CTRL: begin
                                if (q.sr[7:4] == TYPE_CODE && q.sr[3:1] == strap_i && !buf_busy) begin
                                    d.ack = 1'b1;
                                    d.drv = 1'b1;
                                    d.rw  = q.sr[0];
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            ST_ADDR: begin
                                d.ack   = 1'b1;
                                d.drv   = 1'b1;
                                d.addr  = q.sr;
                                d.wptr  = q.sr[IDX_W-1:0];
                                buf_clr = 1'b1;
                            end
                            default: begin
                                d.ack   = 1'b1;
                                d.drv   = 1'b1;
                                d.pend  = 1'b1;
                                buf_cap = 1'b1;
                                d.wptr  = q.wptr + 1'b1;
                                d.addr  = {q.addr[TWI_BYTE_W-1:IDX_W], IDX_W'(q.wptr + 1'b1)};
                            end
                        endcase
                    end else if (scl_fall && q.ack) begin
                        d.ack = 1'b0;
                        d.cnt = '0;
                        d.drv = 1'b0;
                        if (q.st == ST_CTRL) begin
                            if (q.rw) begin
                                d.st   = ST_RDATA;
                                d.tx   = mem_rdata_i;
                                d.drv  = ~mem_rdata_i[TWI_BYTE_W-1];
                                d.addr = q.addr + 1'b1;
                            end else begin
                                d.st = ST_ADDR;
                            end
                        end else begin
                            d.st = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        if (q.ack) d.mack = ~sda_lvl;
                        else       d.cnt  = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.ack) begin
                            d.ack = 1'b0;
                            if (q.mack) begin
                                d.cnt  = '0;
                                d.tx   = mem_rdata_i;
                                d.drv  = ~mem_rdata_i[TWI_BYTE_W-1];
                                d.addr = q.addr + 1'b1;
                            end else begin
                                d.st  = ST_IDLE;
                                d.drv = 1'b0;
                            end
                        end else if (q.cnt == TWI_ACK_SLOT) begin
                            d.ack  = 1'b1;
                            d.drv  = 1'b0;
                            d.mack = 1'b0;
                        end else begin
                            d.tx  = {q.tx[TWI_BYTE_W-2:0], 1'b0};
                            d.drv = ~q.tx[TWI_BYTE_W-2];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_low_o   = q.drv;
    assign perm_addr_o = {q.addr[TWI_BYTE_W-1:IDX_W], q.wptr};
    assign mem_addr_o  = buf_active ? buf_addr : q.addr;
    assign mem_we_o    = buf_we;
    assign mem_wdata_o = buf_wdata;

    logic [PAGE_W-1:0] unused_page;
    assign unused_page = '0;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
    parameter int PAGE_BYTES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_low,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       busy,
    input logic       cmt_active,
    input logic       mem_we,
    input logic [7:0] mem_addr
);
    localparam int IDX_W = $clog2(PAGE_BYTES);

    AST_NO_DRIVE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_low);  // R5

    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmt_active) |-> busy);  // R5

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmt_active) |-> $past(ev_stop));  // R3

    AST_WRITE_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cmt_active);  // R12

    AST_COMMIT_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_active && $past(cmt_active)) |->
            mem_addr[7:IDX_W] == $past(mem_addr[7:IDX_W]));  // R12

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> (!scl_lvl || $past(ev_start || ev_stop)));  // R11
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_low   (sda_low_o),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .busy      (buf_busy),
    .cmt_active(buf_active),
    .mem_we    (mem_we_o),
    .mem_addr  (mem_addr_o)
);

// File: tb/twi_mem_slave_test.sv
module twi_mem_slave_test;
    localparam int H     = 20;
    localparam int BUSY  = 2000;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic uut_low;
    logic [7:0] perm_addr, mem_addr, mem_wdata;
    logic [7:0] mem_rdata;
    logic mem_we, perm_ok;
    logic prot_en = 1'b0;
    logic [7:0] ram [256];
    logic [7:0] exp_mem [256];
    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = ~(m_low | uut_low);
    assign perm_ok = !(prot_en && perm_addr[7:4] == 4'hC && perm_addr[0]);

    twi_mem_slave #(.BUSY_CYCLES(BUSY)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_low_o  (uut_low),
        .strap_i    (STRAP),
        .perm_addr_o(perm_addr),
        .perm_ok_i  (perm_ok),
        .mem_addr_o (mem_addr),
        .mem_we_o   (mem_we),
        .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= 8'h00;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hc();
        repeat (H) @(posedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; hc();
        scl = 1'b1;   hc();
        m_low = 1'b1; hc();
        scl = 1'b0;   hc();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hc();
        scl = 1'b1;   hc();
        m_low = 1'b0; hc();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_low = ~b[7-i]; hc();
            scl = 1'b1;      hc();
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_low = 1'b0; hc();
        scl = 1'b1;
        repeat (H/2) @(negedge clk);
        ack = ~sda_bus;
        repeat (H/2) @(posedge clk);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        b = 8'h00;
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            hc();
            scl = 1'b1;
            repeat (H/2) @(negedge clk);
            b = {b[6:0], sda_bus};
            repeat (H/2) @(posedge clk);
            scl = 1'b0;
        end
        m_low = mack; hc();
        scl = 1'b1;   hc();
        scl = 1'b0;
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] ctrl(input logic rw);
        return {4'b1010, STRAP, rw};
    endfunction

    function automatic logic [7:0] page_addr(input logic [7:0] a, input int k);
        logic [2:0] lo;
        lo = a[2:0] + 3'(k);
        return {a[7:3], lo};
    endfunction

    task automatic wait_ready(output int polls);
        logic ack;
        polls = 0;
        ack = 1'b0;
        while (!ack && polls < 50) begin
            polls++;
            bus_start();
            send_byte(ctrl(1'b0), ack);
            bus_stop();
        end
    endtask

    task automatic write_bytes(input logic [7:0] a, input logic [7:0] d [8], input int n,
                               output int polls);
        logic ack;
        bus_start();
        send_byte(ctrl(1'b0), ack); chk("R1 ack write control", ack, 1);
        send_byte(a, ack);          chk("R3 ack address byte", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack);   chk("R3 R6 ack data byte", ack, 1);
            if (!(prot_en && page_addr(a, k) >= 8'hC0 && page_addr(a, k) <= 8'hCF
                  && page_addr(a, k) % 2 == 1))
                exp_mem[page_addr(a, k)] = d[k];
        end
        bus_stop();
        wait_ready(polls);
    endtask

    task automatic read_from(input logic [7:0] a, input int n, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(ctrl(1'b0), ack); chk("R8 ack dummy write", ack, 1);
        send_byte(a, ack);          chk("R8 ack address", ack, 1);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk("R1 ack read control", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(req, b, exp_mem[8'(a + k)]);
        end
        @(negedge clk);
        chk("R9 SDA released after NACK", uut_low, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        logic ack;
        logic [7:0] b;
        @(negedge clk);
        chk("R11 reset SDA released", uut_low, 0);
        chk("R12 reset no write", mem_we, 0);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk("R1 ack current read", ack, 1);
        recv_byte(1'b0, b);         chk("R7 current read after reset", b, exp_mem[0]);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ack); chk("R2 wrong strap NACK", ack, 0);
        send_byte(8'h00, ack);                   chk("R2 silent after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack);  chk("R2 wrong type NACK", ack, 0);
        bus_stop();
    endtask

    task automatic t_byte_and_busy();
        logic [7:0] d [8];
        int polls;
        d = '{default: 8'h00};
        d[0] = 8'hA5;
        write_bytes(8'h10, d, 1, polls);
        chk("R5 first poll refused", polls > 1, 1);
        chk("R5 poll acked after window", polls < 50, 1);
        read_from(8'h10, 1, "R8 random read byte");
        d[0] = 8'h77;
        write_bytes(8'h2A, d, 1, polls);
    endtask

    task automatic t_page();
        logic [7:0] d [8];
        logic [7:0] b;
        logic ack;
        int polls;
        d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00};
        write_bytes(8'h2E, d, 4, polls);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk("R1 ack current read", ack, 1);
        recv_byte(1'b0, b);         chk("R7 current address after page write", b, 8'h77);
        bus_stop();
        read_from(8'h28, 8, "R3 page wrap contents");
    endtask

    task automatic t_no_stop();
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(ctrl(1'b0), ack);
        send_byte(8'h60, ack);
        send_byte(8'h99, ack);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk("R4 no busy after repeated START", ack, 1);
        recv_byte(1'b0, b);
        bus_stop();
        read_from(8'h60, 1, "R4 repeated START commits nothing");
    endtask

    task automatic t_protect();
        logic [7:0] d [8];
        int polls;
        d = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h00, 8'h00, 8'h00, 8'h00};
        prot_en = 1'b1;
        write_bytes(8'hC4, d, 4, polls);
        prot_en = 1'b0;
        read_from(8'hC4, 4, "R6 protected bytes dropped");
    endtask

    task automatic t_wrap();
        logic [7:0] d [8];
        int polls;
        d = '{8'h3C, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        write_bytes(8'hFE, d, 2, polls);
        d[0] = 8'h81;
        write_bytes(8'h00, d, 1, polls);
        read_from(8'hFE, 3, "R9 sequential read wraps FFh to 00h");
    endtask

    task automatic t_abort();
        logic ack;
        logic [7:0] b;
        int polls;
        bus_start();
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk("R10 START mid-byte restarts decode", ack, 1);
        recv_byte(1'b0, b);
        bus_stop();
        bus_start();
        send_byte(ctrl(1'b0), ack);
        send_byte(8'h50, ack);
        send_byte(8'h11, ack);
        send_bits(8'h22, 3);
        bus_stop();
        exp_mem[8'h50] = 8'h11;
        wait_ready(polls);
        read_from(8'h50, 2, "R10 partial byte not written");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        t_reset();
        t_mismatch();
        t_byte_and_busy();
        t_page();
        t_no_stop();
        t_protect();
        t_wrap();
        t_abort();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule